// File: doc/BRIEF.md
# LMS Adaptive FIR Filter

This block is a sample-serial adaptive FIR filter that learns its coefficients with the least-mean-squares rule. Each accepted input pair holds a reference (noise) sample and a desired sample. The reference sample enters a 22-entry delay line. The filter output is the sum of every delayed sample times its coefficient. The error is the desired sample minus that output. All coefficients are then adjusted from that one error value and their own delayed sample, with the step scaled down by an integer divide.

The datapath has one multiplier for the filter sum and one for the update. It walks the taps one per cycle, first to accumulate the output and then to rewrite the coefficients. The output and error of each sample leave together on one valid/ready stream. After a fixed run of samples the block stops in a terminal state, which only reset leaves.

Top module: `lms_fir`

## Requirements
- R1: After reset, `res_valid_o` and `done_o` are 0, every delay-line entry and every coefficient is 0, and neither input ready is high while no input is valid.
- R2: Each accepted reference sample is placed at tap 0. Each older sample moves up one tap, and the sample that was at tap 21 is discarded.
- R3: `y_o` equals the sum over the 22 taps of tap sample times coefficient, with no scaling. The coefficients used are those in effect before this sample's update.
- R4: `err_o` equals the desired sample minus `y_o` for the same input pair.
- R5: After each sample, every coefficient becomes its old value plus (error × its own tap sample) / 1,000,000, in signed arithmetic with truncation toward zero. The tap sample is the same one used in R3. The new values apply from the next sample on.
- R6: An input pair is consumed only when both `ref_valid_i` and `des_valid_i` are high. `ref_ready_o` and `des_ready_o` are always equal, and are high only when the block is idle and both valids are high.
- R7: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o`, `y_o` and `err_o` stay unchanged.
- R8: After the result of the 40th sample is taken, `done_o` goes high and stays high. From then on, both readies and `res_valid_o` stay low, whatever the inputs do.
- R9: Only one sample is in flight. The readies drop in the cycle after a pair is accepted and stay low until its result has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_valid_i | input | 1 | Reference sample valid |
| ref_data_i | input | 16 | Reference sample, signed |
| ref_ready_o | output | 1 | Reference sample accepted this cycle |
| des_valid_i | input | 1 | Desired sample valid |
| des_data_i | input | 16 | Desired sample, signed |
| des_ready_o | output | 1 | Desired sample accepted this cycle |
| res_valid_o | output | 1 | Output/error result valid |
| res_ready_i | input | 1 | Downstream takes the result |
| y_o | output | 45 | Filter output, signed |
| err_o | output | 46 | Error, signed |
| done_o | output | 1 | Run complete, terminal |

## Verification
The hardest case to reach from the ports is a coefficient update whose quotient is negative and not exact, because floor and truncation give different results only there. The update is also visible only through the next sample's output. A directed run therefore drives reference samples of ±100 against extreme desired values, so that error × tap lands on values such as −1,500,000. The effect then shows up in the following outputs. A random run with random result stalls and one-sided valids covers handshaking, coefficient carry-over across 40 samples and the terminal state.

// File: rtl/lms_fir_pkg.sv
package lms_fir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAC,
    ST_ERR,
    ST_UPD,
    ST_HOLD,
    ST_DONE
  } lms_state_e;
endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line #(
  parameter int NUM_TAPS = 22,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic signed [DATA_W-1:0] din_i,
  input  logic [IDX_W-1:0]         sel_i,
  output logic signed [DATA_W-1:0] tap_o
);
  logic signed [DATA_W-1:0] taps_q [NUM_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps_q[0] <= '0;
    else if (shift_i) taps_q[0] <= din_i;
  end

  for (genvar g = 1; g < NUM_TAPS; g++) begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taps_q[g] <= '0;
      else if (shift_i) taps_q[g] <= taps_q[g-1];
    end
  end

  assign tap_o = taps_q[sel_i];
endmodule

// File: rtl/lms_coef_bank.sv
module lms_coef_bank #(
  parameter int NUM_TAPS = 22,
  parameter int COEF_W   = 24,
  localparam int IDX_W   = $clog2(NUM_TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W-1:0]         sel_i,
  input  logic                     we_i,
  input  logic signed [COEF_W-1:0] wdata_i,
  output logic signed [COEF_W-1:0] coef_o
);
  logic signed [COEF_W-1:0] coef_q [NUM_TAPS];

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) coef_q[g] <= '0;
      else if (we_i && (sel_i == IDX_W'(g))) coef_q[g] <= wdata_i;
    end
  end

  assign coef_o = coef_q[sel_i];
endmodule

// File: rtl/lms_arith.sv
module lms_arith #(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 24,
  parameter int ACC_W    = 45,
  parameter int STEP_DIV = 1000000,
  localparam int ERR_W   = ACC_W + 1,
  localparam int MUL_W   = DATA_W + COEF_W,
  localparam int UPD_W   = ERR_W + DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     mac_en_i,
  input  logic                     err_en_i,
  input  logic signed [DATA_W-1:0] des_i,
  input  logic signed [DATA_W-1:0] tap_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic signed [ERR_W-1:0]  err_o,
  output logic signed [COEF_W-1:0] coef_new_o
);
  logic signed [DATA_W-1:0] des_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ERR_W-1:0]  err_q;
  logic signed [MUL_W-1:0]  mac_prod;
  logic signed [UPD_W-1:0]  upd_prod;
  logic signed [UPD_W-1:0]  upd_step;

  assign mac_prod = MUL_W'(tap_i) * MUL_W'(coef_i);
  assign upd_prod = UPD_W'(err_q) * UPD_W'(tap_i);
  // signed divide truncates toward zero
  assign upd_step = upd_prod / UPD_W'(STEP_DIV);
  assign coef_new_o = coef_i + COEF_W'(upd_step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      des_q <= '0;
      acc_q <= '0;
      err_q <= '0;
    end else begin
      if (load_i) begin
        des_q <= des_i;
        acc_q <= '0;
      end else if (mac_en_i) begin
        acc_q <= acc_q + ACC_W'(mac_prod);
      end
      if (err_en_i) err_q <= ERR_W'(des_q) - ERR_W'(acc_q);
    end
  end

  assign acc_o = acc_q;
  assign err_o = err_q;
endmodule

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_fir_pkg::*;
#(
  parameter int NUM_TAPS = 22,
  parameter int RUN_LEN  = 40,
  localparam int IDX_W   = $clog2(NUM_TAPS),
  localparam int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic             des_valid_i,
  input  logic             res_ready_i,
  output logic             in_ready_o,
  output logic             load_o,
  output logic             mac_en_o,
  output logic             err_en_o,
  output logic             coef_we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             res_valid_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

  lms_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign in_ready_o = (st_q == ST_IDLE) && ref_valid_i && des_valid_i;
  assign accept     = in_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_MAC;
      ST_MAC:  if (idx_q == LAST_IDX) st_d = ST_ERR;
      ST_ERR:  st_d = ST_UPD;
      ST_UPD:  if (idx_q == LAST_IDX) st_d = ST_HOLD;
      ST_HOLD: if (res_ready_i) st_d = (cnt_q == LAST_CNT) ? ST_DONE : ST_IDLE;
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == ST_MAC) || (st_q == ST_UPD))
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      if ((st_q == ST_HOLD) && res_ready_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign load_o      = accept;
  assign mac_en_o    = (st_q == ST_MAC);
  assign err_en_o    = (st_q == ST_ERR);
  assign coef_we_o   = (st_q == ST_UPD);
  assign idx_o       = idx_q;
  assign res_valid_o = (st_q == ST_HOLD);
  assign done_o      = (st_q == ST_DONE);
endmodule

// File: rtl/lms_fir.sv
module lms_fir #(
  parameter int NUM_TAPS = 22,
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 24,
  parameter int RUN_LEN  = 40,
  parameter int STEP_DIV = 1000000,
  localparam int ACC_W   = DATA_W + COEF_W + $clog2(NUM_TAPS),
  localparam int ERR_W   = ACC_W + 1,
  localparam int IDX_W   = $clog2(NUM_TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ref_valid_i,
  input  logic signed [DATA_W-1:0] ref_data_i,
  output logic                     ref_ready_o,
  input  logic                     des_valid_i,
  input  logic signed [DATA_W-1:0] des_data_i,
  output logic                     des_ready_o,
  output logic                     res_valid_o,
  input  logic                     res_ready_i,
  output logic signed [ACC_W-1:0]  y_o,
  output logic signed [ERR_W-1:0]  err_o,
  output logic                     done_o
);
  logic                     in_ready, load, mac_en, err_en, coef_we;
  logic [IDX_W-1:0]         idx;
  logic signed [DATA_W-1:0] tap;
  logic signed [COEF_W-1:0] coef, coef_new;

  lms_ctrl #(.NUM_TAPS(NUM_TAPS), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk_i, .rst_ni,
    .ref_valid_i, .des_valid_i, .res_ready_i,
    .in_ready_o(in_ready), .load_o(load), .mac_en_o(mac_en),
    .err_en_o(err_en), .coef_we_o(coef_we), .idx_o(idx),
    .res_valid_o, .done_o
  );

  lms_tap_line #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W)) u_taps (
    .clk_i, .rst_ni, .shift_i(load), .din_i(ref_data_i),
    .sel_i(idx), .tap_o(tap)
  );

  lms_coef_bank #(.NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i, .rst_ni, .sel_i(idx), .we_i(coef_we),
    .wdata_i(coef_new), .coef_o(coef)
  );

  lms_arith #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
              .STEP_DIV(STEP_DIV)) u_arith (
    .clk_i, .rst_ni, .load_i(load), .mac_en_i(mac_en), .err_en_i(err_en),
    .des_i(des_data_i), .tap_i(tap), .coef_i(coef),
    .acc_o(y_o), .err_o(err_o), .coef_new_o(coef_new)
  );

  assign ref_ready_o = in_ready;
  assign des_ready_o = in_ready;
endmodule

// File: rtl/lms_fir_chk.sv
module lms_fir_chk #(
  parameter int ACC_W = 45,
  parameter int ERR_W = 46
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_valid_i,
  input logic             des_valid_i,
  input logic             ref_ready_o,
  input logic             des_ready_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [ACC_W-1:0] y_o,
  input logic [ERR_W-1:0] err_o,
  input logic             done_o
);
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(y_o) && $stable(err_o)); // R7
  AST_READY_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ready_o |-> ref_valid_i && des_valid_i); // R6
  AST_READY_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ready_o == des_ready_o); // R6
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ref_ready_o && !res_valid_o); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R8
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ready_o |=> !ref_ready_o && !res_valid_o); // R9
  AST_NO_ACCEPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !ref_ready_o); // R9
endmodule

bind lms_fir lms_fir_chk #(.ACC_W(ACC_W), .ERR_W(ERR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_valid_i(ref_valid_i),
  .des_valid_i(des_valid_i), .ref_ready_o(ref_ready_o),
  .des_ready_o(des_ready_o), .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i), .y_o(y_o), .err_o(err_o), .done_o(done_o)
);

// File: tb/lms_fir_bench.sv
module lms_fir_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 22;
  localparam int DW = 16;
  localparam int CW = 24;
  localparam int RUNS = 40;
  localparam int AW = DW + CW + $clog2(NT);
  localparam int EW = AW + 1;

  logic clk = 0, rst_n = 0;
  logic ref_valid = 0, des_valid = 0, res_ready = 0;
  logic signed [DW-1:0] ref_data = '0, des_data = '0;
  logic ref_ready, des_ready, res_valid, done;
  logic signed [AW-1:0] y;
  logic signed [EW-1:0] err;

  int checks = 0, fails = 0;
  longint m_tap [NT];
  longint m_coef[NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  lms_fir u_lms_fir (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_valid_i(ref_valid), .ref_data_i(ref_data), .ref_ready_o(ref_ready),
    .des_valid_i(des_valid), .des_data_i(des_data), .des_ready_o(des_ready),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .y_o(y), .err_o(err), .done_o(done)
  );

  function automatic longint wrap_coef(longint v);
    return (v <<< (64 - CW)) >>> (64 - CW);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NT; i++) begin m_tap[i] = 0; m_coef[i] = 0; end
  endtask

  task automatic model_step(input longint x, input longint d,
                            output longint ey, output longint ee);
    for (int i = NT - 1; i > 0; i--) m_tap[i] = m_tap[i-1];
    m_tap[0] = x;
    ey = 0;
    for (int i = 0; i < NT; i++) ey += m_tap[i] * m_coef[i];
    ee = d - ey;
    for (int i = 0; i < NT; i++) m_coef[i] = wrap_coef(m_coef[i] + (ee * m_tap[i]) / 1000000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ref_valid = 0; des_valid = 0; res_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic run_sample(input int x, input int d, input int stall);
    longint ey, ee, y0, e0;
    @(negedge clk);
    ref_data = DW'(x); des_data = DW'(d);
    ref_valid = 1; des_valid = 1;
    #1;
    while (!ref_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ref_valid = 0; des_valid = 0;
    model_step(x, d, ey, ee);
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    y0 = y; e0 = err;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R7 hold valid", res_valid, 1);
      check("R7 hold y", y, y0);
    end
    check("R3/R2/R5 y", y, ey);
    check("R4 err", err, ee);
    res_ready = 1;
    @(posedge clk); #1;
    res_ready = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    check("R1 res_valid", res_valid, 0);
    check("R1 done", done, 0);
    check("R1 ready", ref_ready, 0);

    // R6: one-sided valid must not be taken
    ref_valid = 1; ref_data = 16'sd77;
    repeat (4) begin @(negedge clk); check("R6 ref only", ref_ready, 0); end
    ref_valid = 0; des_valid = 1;
    repeat (4) begin @(negedge clk); check("R6 des only", des_ready, 0); end
    des_valid = 0;

    // Random run; first y must be 0 since coefficients reset to zero (R1)
    for (int n = 0; n < RUNS; n++) begin
      int x, d;
      x = $signed($urandom_range(200)) - 100;
      d = $signed($urandom_range(6000)) - 3000;
      run_sample(x, d, int'($urandom_range(3)));
    end
    @(negedge clk);
    check("R8 done", done, 1);
    ref_valid = 1; des_valid = 1;
    repeat (6) begin
      @(negedge clk);
      check("R8 no ready", ref_ready, 0);
      check("R8 no result", res_valid, 0);
    end
    ref_valid = 0; des_valid = 0;

    // Directed: negative inexact quotients, truncation toward zero (R5)
    do_reset();
    for (int n = 0; n < RUNS; n++) begin
      int x, d;
      x = (n % 2 == 0) ? 100 : -100;
      d = (n % 3 == 0) ? -15000 : ((n % 3 == 1) ? 32767 : -32768);
      run_sample(x, d, (n == 5) ? 4 : 0);
    end
    @(negedge clk);
    check("R8 done directed", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule